// File: doc/BRIEF.md
# Configurable External Bus Interface

This block sits between an internal requester and the pins of an external memory bus. It takes one request at a time (address, write data, byte enables and a read/write flag) and runs one complete external bus cycle for it. The cycle uses two 16-bit bidirectional ports, an active-low read strobe, an active-low write strobe and an address latch pulse. When the cycle ends, the block returns the read data and a one-clock done pulse.

Three configuration inputs select the bus shape. `cfg_mux_i`=1 selects multiplexed address/data and 0 selects separate address and data ports. `cfg_wide_i`=1 selects a 16-bit data path and 0 an 8-bit one. `cfg_lowwr_i`=1 makes the write strobe a low-byte-only strobe, and 0 makes it a plain write strobe.

The role of each bit of port 0 is remapped per mode. In every mode, a port bit that the bus does not own falls back to general-purpose use under its own direction and output bits. The configuration is taken only while the bus is idle. With the default `STRB_CYC`=2, a multiplexed cycle takes 1 address clock, 2 strobe clocks and 1 recovery clock. A demultiplexed cycle drops the address clock.

Top module: `ebi_ctrl`

## Requirements
- R1: After reset, `rd_n_o` and `wr_n_o` are 1, and `ale_o`, `done_o` and `busy_o` are 0.
- R2: In multiplexed mode, counting clock 1 as the first clock after the accepting edge:
  - `ale_o` is 1 for exactly clock 1, with the full request address on `p0_o` and `p0_oe_o` all ones.
  - The strobe is active for clocks 2 to STRB_CYC+1, with no strobe during ALE.
  - Clock STRB_CYC+2 is a recovery clock.
  - `done_o` is 1 in clock STRB_CYC+3.
- R3: In demultiplexed mode, `ale_o` stays 0 for the whole cycle.
  - `p1_o` holds the address, with `p1_oe_o` all ones, from clock 1 through the recovery clock STRB_CYC+1.
  - The strobe is active for clocks 1 to STRB_CYC.
  - `done_o` is 1 in clock STRB_CYC+2.
- R4: `rd_n_o` is active for every read, and the data lanes of port 0 are released (oe 0) while it is active.
  - Data is sampled at the clock edge that ends the last strobe clock.
  - On a 16-bit path, `rdata_o` = `p0_i`.
  - On an 8-bit path, `rdata_o` = {`p0_i[7:0]`,`p0_i[7:0]`}.
- R5: While `wr_n_o` is active, port 0 drives the write data on its data lanes.
  - On a 16-bit path, all 16 bits of `req_wdata_i` are driven.
  - On an 8-bit path, `p0_o[7:0]` carries `req_wdata_i[15:8]` when `req_be_i`=2'b10, and `req_wdata_i[7:0]` otherwise.
- R6: In plain write mode, `wr_n_o` is active for every write, whatever the byte enables.
- R7: In low-byte write mode on a 16-bit path, `wr_n_o` is active only when `req_be_i[0]`=1. A write without the low byte still runs a cycle of the same length and ends with `done_o`.
- R8: In low-byte write mode on an 8-bit path, `wr_n_o` is active for every write.
- R9: Bits the bus does not own follow `pX_dir_i` for oe and `pX_gpo_i` for the output value.
  - Port 1 is not owned in multiplexed modes.
  - `p0[15:8]` is not owned in 8-bit demultiplexed mode.
- R10: Bits owned by the bus in the current mode have their output enable at 0 while the bus is idle.
- R11: In multiplexed 8-bit mode, `p0_o[15:8]` carries address bits 15:8 with oe on for the whole cycle, including the data phase.
- R12: A configuration change while a cycle runs does not alter that cycle. `rd_n_o` and `wr_n_o` are never active together, and `done_o` lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_mux_i | input | 1 | 1 = multiplexed address/data |
| cfg_wide_i | input | 1 | 1 = 16-bit data path |
| cfg_lowwr_i | input | 1 | 1 = low-byte write strobe mode |
| req_i | input | 1 | Request, accepted while idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 = low byte |
| busy_o | output | 1 | Bus cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data |
| p0_i | input | 16 | Port 0 pin input |
| p0_o | output | 16 | Port 0 pin output |
| p0_oe_o | output | 16 | Port 0 output enable |
| p0_dir_i | input | 16 | Port 0 general-purpose direction (1 = output) |
| p0_gpo_i | input | 16 | Port 0 general-purpose output value |
| p1_o | output | 16 | Port 1 pin output |
| p1_oe_o | output | 16 | Port 1 output enable |
| p1_dir_i | input | 16 | Port 1 general-purpose direction |
| p1_gpo_i | input | 16 | Port 1 general-purpose output value |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write or low-byte write strobe, active low |
| ale_o | output | 1 | Address latch enable |

## Verification
The bench goes after the following corner cases:

- **Low-byte write strobe on a 16-bit path with only the high byte enabled.** A design that strobes anyway would corrupt the low byte in external memory. A design that skips the cycle entirely would never return done.
- **Low-byte write strobe on an 8-bit path.** A design that applies the 16-bit rule there would drop writes.
- **Multiplexed 8-bit mode.** A design that releases all of port 0 in the data phase would lose the upper address bits.
- **8-bit demultiplexed mode.** A design that claims the upper half of port 0 would override general-purpose outputs.
- **Configuration change mid-cycle.** A design that samples the configuration while busy would switch port roles half way, dropping the strobe or returning a truncated byte.
- **Cycle timing.** Exact clock counts of ALE, strobe and done, and the data lanes released during reads, are checked so that an off-by-one in the phase counter or a bus fight is caught.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_STRB  = 2'd2,
    ST_RECOV = 2'd3
  } ebi_state_e;

  typedef struct packed {
    logic mux;
    logic wide;
    logic lowwr;
  } ebi_cfg_t;
endpackage

// File: rtl/ebi_seq.sv
module ebi_seq
  import ebi_pkg::*;
#(
  parameter int PORT_W   = 16,
  parameter int STRB_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ebi_cfg_t          cfg_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [PORT_W-1:0] req_addr_i,
  input  logic [PORT_W-1:0] req_wdata_i,
  input  logic [1:0]        req_be_i,
  input  logic [PORT_W-1:0] p0_i,
  output ebi_state_e        st_o,
  output ebi_cfg_t          cfg_q_o,
  output logic              we_q_o,
  output logic [PORT_W-1:0] addr_q_o,
  output logic [PORT_W-1:0] wdata_q_o,
  output logic [1:0]        be_q_o,
  output logic [PORT_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int BYTE_W = PORT_W / 2;
  localparam int CNT_W  = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRB_CYC - 1);

  ebi_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             strb_last;

  assign accept    = (st_q == ST_IDLE) && req_i;
  assign strb_last = (st_q == ST_STRB) && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q  <= cfg_i.mux ? ST_ADDR : ST_STRB;
          cnt_q <= '0;
        end
        ST_ADDR: begin
          st_q  <= ST_STRB;
          cnt_q <= '0;
        end
        ST_STRB: begin
          if (strb_last) st_q <= ST_RECOV;
          else           cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // configuration tracks inputs only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q_o <= '{mux: 1'b0, wide: 1'b1, lowwr: 1'b0};
    else if (st_q == ST_IDLE) cfg_q_o <= cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q_o    <= 1'b0;
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      be_q_o    <= '0;
    end else if (accept) begin
      we_q_o    <= req_we_i;
      addr_q_o  <= req_addr_i;
      wdata_q_o <= req_wdata_i;
      be_q_o    <= req_be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (strb_last && !we_q_o)
      rdata_o <= cfg_q_o.wide ? p0_i : {p0_i[BYTE_W-1:0], p0_i[BYTE_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= (st_q == ST_RECOV);
  end

  assign st_o = st_q;
endmodule

// File: rtl/ebi_strobe.sv
module ebi_strobe
  import ebi_pkg::*;
(
  input  ebi_state_e st_i,
  input  logic       wide_i,
  input  logic       lowwr_i,
  input  logic       we_i,
  input  logic       be0_i,
  output logic       rd_n_o,
  output logic       wr_n_o,
  output logic       ale_o
);
  logic wr_allow;

  // low-byte strobe only gates on a 16-bit path
  assign wr_allow = !(lowwr_i && wide_i) || be0_i;
  assign rd_n_o   = !((st_i == ST_STRB) && !we_i);
  assign wr_n_o   = !((st_i == ST_STRB) && we_i && wr_allow);
  assign ale_o    = (st_i == ST_ADDR);
endmodule

// File: rtl/ebi_pinmux.sv
module ebi_pinmux
  import ebi_pkg::*;
#(
  parameter int PORT_W = 16
) (
  input  ebi_state_e        st_i,
  input  logic              mux_i,
  input  logic              wide_i,
  input  logic              we_i,
  input  logic [PORT_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  input  logic [PORT_W-1:0] p0_dir_i,
  input  logic [PORT_W-1:0] p0_gpo_i,
  input  logic [PORT_W-1:0] p1_dir_i,
  input  logic [PORT_W-1:0] p1_gpo_i,
  output logic [PORT_W-1:0] p0_o,
  output logic [PORT_W-1:0] p0_oe_o,
  output logic [PORT_W-1:0] p1_o,
  output logic [PORT_W-1:0] p1_oe_o
);
  localparam int BYTE_W = PORT_W / 2;

  logic              addr_ph, data_ph;
  logic [PORT_W-1:0] lanes, own0, own1;
  logic [PORT_W-1:0] bo0, boe0, bo1, boe1;
  logic [BYTE_W-1:0] wbyte;

  always_comb begin
    addr_ph = (st_i == ST_ADDR);
    data_ph = (st_i == ST_STRB) || (st_i == ST_RECOV);
    lanes   = wide_i ? {PORT_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    own0    = mux_i ? {PORT_W{1'b1}} : lanes;
    own1    = {PORT_W{!mux_i}};
    wbyte   = (be_i == 2'b10) ? wdata_i[PORT_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];
    bo0     = '0;
    boe0    = '0;
    if (addr_ph) begin
      bo0  = addr_i;
      boe0 = '1;
    end else if (data_ph) begin
      bo0  = wide_i ? wdata_i : {addr_i[PORT_W-1:BYTE_W], wbyte};
      boe0 = we_i ? lanes : '0;
      // narrow multiplexed: upper half keeps the address
      if (mux_i && !wide_i) boe0[PORT_W-1:BYTE_W] = '1;
    end
    bo1  = addr_i;
    boe1 = {PORT_W{data_ph}};
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    assign p0_o[i]    = own0[i] ? bo0[i]  : p0_gpo_i[i];
    assign p0_oe_o[i] = own0[i] ? boe0[i] : p0_dir_i[i];
    assign p1_o[i]    = own1[i] ? bo1[i]  : p1_gpo_i[i];
    assign p1_oe_o[i] = own1[i] ? boe1[i] : p1_dir_i[i];
  end
endmodule

// File: rtl/ebi_ctrl.sv
module ebi_ctrl
  import ebi_pkg::*;
#(
  parameter int PORT_W   = 16,
  parameter int STRB_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mux_i,
  input  logic              cfg_wide_i,
  input  logic              cfg_lowwr_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [PORT_W-1:0] req_addr_i,
  input  logic [PORT_W-1:0] req_wdata_i,
  input  logic [1:0]        req_be_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PORT_W-1:0] p0_i,
  output logic [PORT_W-1:0] p0_o,
  output logic [PORT_W-1:0] p0_oe_o,
  input  logic [PORT_W-1:0] p0_dir_i,
  input  logic [PORT_W-1:0] p0_gpo_i,
  output logic [PORT_W-1:0] p1_o,
  output logic [PORT_W-1:0] p1_oe_o,
  input  logic [PORT_W-1:0] p1_dir_i,
  input  logic [PORT_W-1:0] p1_gpo_i,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              ale_o
);
  ebi_state_e        st;
  ebi_cfg_t          cfg_in, cfg_q;
  logic              we_q;
  logic [PORT_W-1:0] addr_q, wdata_q;
  logic [1:0]        be_q;
  logic              mux_q, wide_q, lowwr_q, be0_q;

  assign cfg_in  = '{mux: cfg_mux_i, wide: cfg_wide_i, lowwr: cfg_lowwr_i};
  assign mux_q   = cfg_q.mux;
  assign wide_q  = cfg_q.wide;
  assign lowwr_q = cfg_q.lowwr;
  assign be0_q   = be_q[0];
  assign busy_o  = (st != ST_IDLE);

  ebi_seq #(.PORT_W(PORT_W), .STRB_CYC(STRB_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg_in),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_be_i    (req_be_i),
    .p0_i        (p0_i),
    .st_o        (st),
    .cfg_q_o     (cfg_q),
    .we_q_o      (we_q),
    .addr_q_o    (addr_q),
    .wdata_q_o   (wdata_q),
    .be_q_o      (be_q),
    .rdata_o     (rdata_o),
    .done_o      (done_o)
  );

  ebi_strobe u_strobe (
    .st_i    (st),
    .wide_i  (wide_q),
    .lowwr_i (lowwr_q),
    .we_i    (we_q),
    .be0_i   (be0_q),
    .rd_n_o  (rd_n_o),
    .wr_n_o  (wr_n_o),
    .ale_o   (ale_o)
  );

  ebi_pinmux #(.PORT_W(PORT_W)) u_pinmux (
    .st_i     (st),
    .mux_i    (mux_q),
    .wide_i   (wide_q),
    .we_i     (we_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .be_i     (be_q),
    .p0_dir_i (p0_dir_i),
    .p0_gpo_i (p0_gpo_i),
    .p1_dir_i (p1_dir_i),
    .p1_gpo_i (p1_gpo_i),
    .p0_o     (p0_o),
    .p0_oe_o  (p0_oe_o),
    .p1_o     (p1_o),
    .p1_oe_o  (p1_oe_o)
  );
endmodule

// File: rtl/ebi_ctrl_chk.sv
module ebi_ctrl_chk #(
  parameter int PORT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic              ale_o,
  input logic              done_o,
  input logic              busy_o,
  input logic [PORT_W-1:0] p1_o,
  input logic              mux_q,
  input logic              wide_q,
  input logic              lowwr_q,
  input logic              be0_q
);
  assert_rd_wr_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_n_o && wr_n_o && !ale_o));

  assert_no_ale_demux_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mux_q |-> !ale_o);

  assert_ale_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  assert_ale_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o && busy_o));

  assert_rd_then_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n_o) |=> done_o);

  assert_lowwr_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o && lowwr_q && wide_q) |-> be0_q);

  assert_p1_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mux_q && !rd_n_o && $past(!rd_n_o)) |-> $stable(p1_o));
endmodule

bind ebi_ctrl ebi_ctrl_chk #(.PORT_W(PORT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_n_o  (rd_n_o),
  .wr_n_o  (wr_n_o),
  .ale_o   (ale_o),
  .done_o  (done_o),
  .busy_o  (busy_o),
  .p1_o    (p1_o),
  .mux_q   (mux_q),
  .wide_q  (wide_q),
  .lowwr_q (lowwr_q),
  .be0_q   (be0_q)
);

// File: tb/ebi_ctrl_test.sv
`timescale 1ns/1ps
module ebi_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_mux_i = 1'b0, cfg_wide_i = 1'b1, cfg_lowwr_i = 1'b0;
  logic        req_i = 1'b0, req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic [1:0]  req_be_i = 2'b11;
  logic        busy_o, done_o, rd_n_o, wr_n_o, ale_o;
  logic [15:0] rdata_o, p0_o, p0_oe_o, p1_o, p1_oe_o;
  logic [15:0] p0_i = '0, p0_dir_i = 16'hFFFF, p0_gpo_i = 16'h0000;
  logic [15:0] p1_dir_i = 16'hFFFF, p1_gpo_i = 16'h0000;

  int n_chk = 0, n_fail = 0;
  int n_ale, ale_k, n_rd, n_wr, first_k, done_k, both, p1_cnt;
  logic [15:0] ale_p0, ale_oe, rd_oe, wr_p0, wr_oe, rdat, s_p0, s_oe, s_p1, s_p1oe;
  logic done_after;

  always #5 clk_i = ~clk_i;

  ebi_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic set_cfg(input logic m, input logic w, input logic l);
    @(negedge clk_i);
    cfg_mux_i = m; cfg_wide_i = w; cfg_lowwr_i = l;
  endtask

  task automatic run_txn(input logic we, input logic [15:0] a, input logic [15:0] wd,
                         input logic [1:0] be, input logic flip);
    n_ale = 0; ale_k = 0; n_rd = 0; n_wr = 0; first_k = 0; done_k = 0; both = 0; p1_cnt = 0;
    ale_p0 = '0; ale_oe = '0; rd_oe = '1; wr_p0 = '0; wr_oe = '0; rdat = '0;
    s_p0 = '0; s_oe = '0; s_p1 = '0; s_p1oe = '0;
    @(negedge clk_i);
    req_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = wd; req_be_i = be;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      if (ale_o) begin n_ale++; ale_k = k; ale_p0 = p0_o; ale_oe = p0_oe_o; end
      if (!rd_n_o) begin
        n_rd++; if (first_k == 0) first_k = k; rd_oe = p0_oe_o;
        s_p0 = p0_o; s_oe = p0_oe_o; s_p1 = p1_o; s_p1oe = p1_oe_o;
      end
      if (!wr_n_o) begin
        n_wr++; if (first_k == 0) first_k = k; wr_p0 = p0_o; wr_oe = p0_oe_o;
        s_p0 = p0_o; s_oe = p0_oe_o; s_p1 = p1_o; s_p1oe = p1_oe_o;
      end
      if (!rd_n_o && !wr_n_o) both++;
      if (p1_oe_o == 16'hFFFF && p1_o == a) p1_cnt++;
      if (done_o) begin done_k = k; rdat = rdata_o; break; end
      if (flip && k == 1) begin cfg_mux_i = 1'b0; cfg_wide_i = 1'b0; end
      @(negedge clk_i);
    end
    @(negedge clk_i);
    done_after = done_o;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 rd_n", rd_n_o, 1);
    chk("R1 wr_n", wr_n_o, 1);
    chk("R1 ale", ale_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R10 p0 oe idle", p0_oe_o, 16'h0000);
    chk("R10 p1 oe idle", p1_oe_o, 16'h0000);
  endtask

  task automatic t_mux16_read;
    p1_dir_i = 16'h00F0; p1_gpo_i = 16'h0A50; p0_i = 16'hBEEF;
    set_cfg(1, 1, 0);
    run_txn(0, 16'h1234, 16'h0, 2'b11, 0);
    chk("R2 ale count", n_ale, 1);
    chk("R2 ale clock", ale_k, 1);
    chk("R2 ale addr", ale_p0, 16'h1234);
    chk("R2 ale oe", ale_oe, 16'hFFFF);
    chk("R2 first strobe", first_k, 2);
    chk("R4 rd count", n_rd, 2);
    chk("R4 lanes released", rd_oe, 16'h0000);
    chk("R2 done clock", done_k, 5);
    chk("R4 rdata16", rdat, 16'hBEEF);
    chk("R9 p1 gpio oe", s_p1oe, 16'h00F0);
    chk("R9 p1 gpio out", s_p1, 16'h0A50);
    chk("R12 done width", done_after, 0);
    chk("R12 no overlap", both, 0);
  endtask

  task automatic t_mux8_write;
    set_cfg(1, 0, 0);
    run_txn(1, 16'hABCD, 16'h1122, 2'b10, 0);
    chk("R2 mux8 ale addr", ale_p0, 16'hABCD);
    chk("R6 wr count", n_wr, 2);
    chk("R4 no rd on write", n_rd, 0);
    chk("R5 R11 mux8 wdata", wr_p0, 16'hAB11);
    chk("R11 mux8 oe", wr_oe, 16'hFFFF);
    chk("R2 mux8 done", done_k, 5);
  endtask

  task automatic t_mux8_read;
    p0_i = 16'h77C3;
    set_cfg(1, 0, 0);
    run_txn(0, 16'h9A5E, 16'h0, 2'b01, 0);
    chk("R11 mux8 read hi addr", s_p0[15:8], 8'h9A);
    chk("R11 mux8 read oe", s_oe, 16'hFF00);
    chk("R4 rdata8 mux", rdat, 16'hC3C3);
  endtask

  task automatic t_demux16_write;
    set_cfg(0, 1, 0);
    run_txn(1, 16'h4321, 16'hCAFE, 2'b10, 0);
    chk("R3 no ale", n_ale, 0);
    chk("R3 first strobe", first_k, 1);
    chk("R6 plain wr hi-only", n_wr, 2);
    chk("R5 wdata16", wr_p0, 16'hCAFE);
    chk("R5 oe16", wr_oe, 16'hFFFF);
    chk("R3 p1 addr cycles", p1_cnt, 3);
    chk("R3 done clock", done_k, 4);
    chk("R10 p1 idle after", p1_oe_o, 16'h0000);
  endtask

  task automatic t_demux8_read;
    p0_dir_i = 16'hFF00; p0_gpo_i = 16'h5A00; p0_i = 16'hA55A;
    set_cfg(0, 0, 0);
    run_txn(0, 16'h0F0F, 16'h0, 2'b01, 0);
    chk("R9 p0 hi gpio oe", s_oe[15:8], 8'hFF);
    chk("R9 p0 hi gpio out", s_p0[15:8], 8'h5A);
    chk("R4 low lane released", s_oe[7:0], 8'h00);
    chk("R4 rdata8", rdat, 16'h5A5A);
    chk("R3 demux8 done", done_k, 4);
    p0_dir_i = 16'hFFFF; p0_gpo_i = 16'h0000;
  endtask

  task automatic t_lowwr16;
    set_cfg(0, 1, 1);
    run_txn(1, 16'h2000, 16'h3344, 2'b10, 0);
    chk("R7 hi-only no strobe", n_wr, 0);
    chk("R7 hi-only done", done_k, 4);
    run_txn(1, 16'h2002, 16'h5566, 2'b01, 0);
    chk("R7 low strobe", n_wr, 2);
  endtask

  task automatic t_lowwr8;
    set_cfg(0, 0, 1);
    run_txn(1, 16'h3001, 16'h99EE, 2'b10, 0);
    chk("R8 8-bit strobe", n_wr, 2);
    chk("R5 8-bit hi byte", wr_p0[7:0], 8'h99);
  endtask

  task automatic t_cfg_change;
    p0_i = 16'h1357;
    set_cfg(1, 1, 0);
    run_txn(0, 16'h8888, 16'h0, 2'b11, 1);
    chk("R12 cfg change ale", n_ale, 1);
    chk("R12 cfg change done", done_k, 5);
    chk("R12 cfg change rdata", rdat, 16'h1357);
    set_cfg(0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_mux16_read();
    t_mux8_write();
    t_mux8_read();
    t_demux16_write();
    t_demux8_read();
    t_lowwr16();
    t_lowwr8();
    t_cfg_change();
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule